// File: doc/BRIEF.md
# Infrared Transceiver Mode Controller

This block is the digital control core of an infrared link transceiver that carries both a data emitter and a remote-control emitter. It watches a power-down input and two transmit-data inputs, all sampled on one clock, and produces enable signals for the data LED driver, the remote-control LED driver and the receiver output stage. It never drives any analog circuit directly.

A three-way mode register selects low-rate data (the default), high-rate data, or remote-control drive. The mode is set by a short high pulse on the power-down input. The level and history of the data transmit input during that pulse decide the new mode, and the mode is taken on the pulse's falling edge. A long power-down pulse is a full shutdown instead: all emitters go dark, the receiver is disabled and the mode returns to the default. A watchdog on each drive input turns off an emitter whose input has stayed high for too long.

All time limits are given in nanoseconds and turned into clock counts from the clock-frequency parameter. Inputs pass through a synchronizer first, and every output is registered.

Top module: `irtx_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 00 (low-rate), both LED enables are 0 and `rx_en` is 1.
- R2: If `sd_in` is held high for at least SHUTDOWN_NS, the block is in full shutdown. While in it, `rx_en` is 0, both LED enables are 0 and `mode_o` is 00. Once `sd_in` returns low, `rx_en` is 1 again and the mode stays 00.
- R3: An `sd_in` high pulse no longer than PROG_MAX_NS is a programming pulse. If `tx_ir_in` is high at its falling edge, `mode_o` becomes 01 (high-rate). Otherwise, if no remote-control arm (R4) was recorded, `mode_o` becomes 00.
- R4: During a programming pulse, a `tx_ir_in` high run of at least RC_PULSE_NS records a remote-control arm. The run counts only once `sd_in` has been high for RC_SETUP_NS, and it must end while `sd_in` is still high. With `tx_ir_in` low at the falling edge, an armed pulse sets `mode_o` to 10 (remote control). A shorter run does not arm.
- R5: An `sd_in` pulse longer than PROG_MAX_NS but shorter than SHUTDOWN_NS leaves the mode unchanged. The mode changes only on a programming falling edge or on shutdown entry.
- R6: In modes 00 and 01 with `sd_in` low: `tx_ir_in` high alone lights the data LED, `tx_rc_in` high alone lights the remote-control LED, and both low leaves both LEDs off with `rx_en` 1.
- R7: In modes 00 and 01, when both transmit inputs are high, both LEDs are off. The two LED enables are never high together.
- R8: In mode 10, `tx_ir_in` drives the remote-control LED, the data LED stays off, and `tx_rc_in` has no effect.
- R9: A drive input held high for STUCK_NS or longer forces its LED off until that input returns low. A fresh high then lights the LED again.
- R10: While `sd_in` is high, both LED enables are 0 whatever the transmit inputs do.
- R11: `mode_o` only takes the values 00, 01 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| sd_in | input | 1 | Power-down / mode-programming input, active high |
| tx_ir_in | input | 1 | Data-emitter transmit input, also used as mode data |
| tx_rc_in | input | 1 | Remote-control transmit input |
| ir_led_en | output | 1 | Data LED driver enable |
| rc_led_en | output | 1 | Remote-control LED driver enable |
| rx_en | output | 1 | Receiver output enable; 0 means tri-stated |
| mode_o | output | 2 | Current mode: 00 low-rate, 01 high-rate, 10 remote control |

## Verification
The bench builds the block with a 50 MHz sampling clock and the default nanosecond limits. That gives 1500 cycles for shutdown, 250 for the longest programming pulse, 10 each for remote-control setup and pulse, and 2500 for the LED watchdog. These counts keep every threshold reachable in a short run. Both sides of the shutdown and watchdog limits can be probed with margin, and pulses of 4 and 20 cycles fall clearly on each side of the remote-control arming limit.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  typedef enum logic [1:0] {
    MODE_SIR  = 2'b00,
    MODE_FAST = 2'b01,
    MODE_RC   = 2'b10
  } irtx_mode_e;

  // Round a time in nanoseconds up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                               input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/irtx_sync.sv
module irtx_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/irtx_run_timer.sv
// Counts consecutive cycles with run high, saturating at LIMIT; clears
// on the edge after run goes low, so the run length is still visible
// during the first low cycle.
module irtx_run_timer #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                    count <= '0;
    else if (!run)              count <= '0;
    else if (count != CW'(LIMIT)) count <= count + 1'b1;
  end

  assert_count_bounded_R9: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(LIMIT));
endmodule

// File: rtl/irtx_mode_reg.sv
module irtx_mode_reg
  import irtx_pkg::*;
#(
  parameter int unsigned SD_CYC    = 1500,
  parameter int unsigned PROG_CYC  = 250,
  parameter int unsigned SETUP_CYC = 10,
  parameter int unsigned PULSE_CYC = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sd_s,
  input  logic       tir_s,
  output irtx_mode_e mode_q,
  output logic       shut_q
);
  localparam int unsigned SW = $clog2(SD_CYC + 1);
  localparam int unsigned PW = $clog2(PULSE_CYC + 1);

  logic [SW-1:0] sd_cnt;
  logic [PW-1:0] tb_cnt;
  logic          sd_prev, rc_arm;
  logic          setup_ok, tb_run, fall, prog_ok, shut_set, tb_done;

  // Length of the current shutdown-high run.
  irtx_run_timer #(.LIMIT(SD_CYC)) u_sd_timer (
    .clk(clk), .rst(rst), .run(sd_s), .count(sd_cnt));

  assign setup_ok = (sd_cnt >= SW'(SETUP_CYC));
  assign tb_run   = sd_s & tir_s & setup_ok;

  // Length of the transmit-high run inside a programming window.
  irtx_run_timer #(.LIMIT(PULSE_CYC)) u_tb_timer (
    .clk(clk), .rst(rst), .run(tb_run), .count(tb_cnt));

  assign tb_done  = (tb_cnt == PW'(PULSE_CYC));
  assign fall     = sd_prev & ~sd_s;
  assign prog_ok  = (sd_cnt <= SW'(PROG_CYC));
  assign shut_set = sd_s & (sd_cnt >= SW'(SD_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_SIR;
      shut_q  <= 1'b0;
      sd_prev <= 1'b0;
      rc_arm  <= 1'b0;
    end else begin
      sd_prev <= sd_s;
      shut_q  <= shut_set;
      if (!sd_s)                rc_arm <= 1'b0;
      else if (!tir_s && tb_done) rc_arm <= 1'b1;
      if (shut_set) begin
        mode_q <= MODE_SIR;
      end else if (fall && prog_ok) begin
        if (tir_s)       mode_q <= MODE_FAST;
        else if (rc_arm) mode_q <= MODE_RC;
        else             mode_q <= MODE_SIR;
      end
    end
  end

  assert_mode_legal_R11: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'b11);

  assert_shut_default_R2: assert property (@(posedge clk) disable iff (rst)
    shut_q |-> mode_q == MODE_SIR);

  assert_mode_only_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> ($past(fall) || shut_q));
endmodule

// File: rtl/irtx_led_gate.sv
module irtx_led_gate
  import irtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sd_s,
  input  logic       shut_q,
  input  irtx_mode_e mode,
  input  logic       tir_s,
  input  logic       trc_s,
  input  logic       tir_stuck,
  input  logic       trc_stuck,
  output logic       ir_led_en,
  output logic       rc_led_en,
  output logic       rx_en
);
  logic ir_nxt, rc_nxt;

  always_comb begin
    ir_nxt = 1'b0;
    rc_nxt = 1'b0;
    if (!sd_s) begin
      if (mode == MODE_RC) begin
        rc_nxt = tir_s & ~tir_stuck;
      end else begin
        ir_nxt = tir_s & ~trc_s & ~tir_stuck;
        rc_nxt = trc_s & ~tir_s & ~trc_stuck;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_led_en <= 1'b0;
      rc_led_en <= 1'b0;
      rx_en     <= 1'b1;
    end else begin
      ir_led_en <= ir_nxt;
      rc_led_en <= rc_nxt;
      rx_en     <= ~shut_q;
    end
  end

  assert_leds_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(ir_led_en && rc_led_en));

  assert_rc_mode_no_ir_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RC) |=> !ir_led_en);

  assert_stuck_blocks_ir_R9: assert property (@(posedge clk) disable iff (rst)
    tir_stuck |=> !ir_led_en);
endmodule

// File: rtl/irtx_mode_ctrl.sv
module irtx_mode_ctrl
  import irtx_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned SHUTDOWN_NS = 30_000,
  parameter int unsigned PROG_MAX_NS = 5_000,
  parameter int unsigned RC_SETUP_NS = 200,
  parameter int unsigned RC_PULSE_NS = 200,
  parameter int unsigned STUCK_NS    = 50_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sd_in,
  input  logic       tx_ir_in,
  input  logic       tx_rc_in,
  output logic       ir_led_en,
  output logic       rc_led_en,
  output logic       rx_en,
  output logic [1:0] mode_o
);
  localparam int unsigned SD_CYC    = ns_to_cycles(SHUTDOWN_NS, CLK_HZ);
  localparam int unsigned PROG_CYC  = ns_to_cycles(PROG_MAX_NS, CLK_HZ);
  localparam int unsigned SETUP_CYC = ns_to_cycles(RC_SETUP_NS, CLK_HZ);
  localparam int unsigned PULSE_CYC = ns_to_cycles(RC_PULSE_NS, CLK_HZ);
  localparam int unsigned STK_CYC   = ns_to_cycles(STUCK_NS, CLK_HZ);
  localparam int unsigned KW        = $clog2(STK_CYC + 1);

  logic [2:0] raw, synced;
  logic       sd_s;
  logic [1:0] tx_s, stuck;
  irtx_mode_e mode_q;
  logic       shut_q;

  assign raw = {sd_in, tx_ir_in, tx_rc_in};

  irtx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced));

  assign sd_s = synced[2];
  assign tx_s = synced[1:0];   // [1] data input, [0] remote-control input

  // One hold-time watchdog per drive input.
  for (genvar g = 0; g < 2; g++) begin : g_stuck
    logic [KW-1:0] hold_cnt;
    irtx_run_timer #(.LIMIT(STK_CYC)) u_hold (
      .clk(clk), .rst(rst), .run(tx_s[g]), .count(hold_cnt));
    assign stuck[g] = (hold_cnt == KW'(STK_CYC));
  end

  irtx_mode_reg #(
    .SD_CYC(SD_CYC), .PROG_CYC(PROG_CYC),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)
  ) u_mode (
    .clk(clk), .rst(rst), .sd_s(sd_s), .tir_s(tx_s[1]),
    .mode_q(mode_q), .shut_q(shut_q));

  irtx_led_gate u_gate (
    .clk(clk), .rst(rst), .sd_s(sd_s), .shut_q(shut_q), .mode(mode_q),
    .tir_s(tx_s[1]), .trc_s(tx_s[0]),
    .tir_stuck(stuck[1]), .trc_stuck(stuck[0]),
    .ir_led_en(ir_led_en), .rc_led_en(rc_led_en), .rx_en(rx_en));

  assign mode_o = mode_q;

  assert_shutdown_dark_R2: assert property (@(posedge clk) disable iff (rst)
    (shut_q && $past(shut_q)) |-> (!ir_led_en && !rc_led_en));
endmodule

// File: tb/irtx_mode_ctrl_tb.sv
`timescale 1ns/1ps
module irtx_mode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic sd_in, tx_ir_in, tx_rc_in;
  logic ir_led_en, rc_led_en, rx_en;
  logic [1:0] mode_o;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  irtx_mode_ctrl #(.CLK_HZ(50_000_000)) dut_i (
    .clk(clk), .rst(rst), .sd_in(sd_in), .tx_ir_in(tx_ir_in),
    .tx_rc_in(tx_rc_in), .ir_led_en(ir_led_en), .rc_led_en(rc_led_en),
    .rx_en(rx_en), .mode_o(mode_o));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Short programming pulse; tx_ir level held across the falling edge.
  task automatic program_level(input logic lvl);
    sd_in = 1'b1; step(20);
    tx_ir_in = lvl; step(30);
    sd_in = 1'b0; step(5);
    tx_ir_in = 1'b0; step(8);
  endtask

  // Short programming pulse with a tx_ir burst of burst cycles that ends
  // before the falling edge.
  task automatic program_burst(input int burst);
    sd_in = 1'b1; step(20);
    tx_ir_in = 1'b1; step(burst);
    tx_ir_in = 1'b0; step(10);
    sd_in = 1'b0; step(8);
  endtask

  task automatic t_reset;
    rst = 1'b1; sd_in = 0; tx_ir_in = 0; tx_rc_in = 0;
    step(5); rst = 1'b0; step(4);
    chk("R1", "mode after reset", mode_o, 0);
    chk("R1", "ir led after reset", ir_led_en, 0);
    chk("R1", "rc led after reset", rc_led_en, 0);
    chk("R1", "rx_en after reset", rx_en, 1);
  endtask

  task automatic t_direct_drive;
    tx_ir_in = 1; step(5);
    chk("R6", "ir alone -> ir led", ir_led_en, 1);
    chk("R6", "ir alone -> rc led", rc_led_en, 0);
    tx_ir_in = 0; tx_rc_in = 1; step(5);
    chk("R6", "rc alone -> ir led", ir_led_en, 0);
    chk("R6", "rc alone -> rc led", rc_led_en, 1);
    tx_ir_in = 1; step(5);
    chk("R7", "both high -> ir led", ir_led_en, 0);
    chk("R7", "both high -> rc led", rc_led_en, 0);
    tx_ir_in = 0; tx_rc_in = 0; step(5);
    chk("R6", "idle ir led", ir_led_en, 0);
    chk("R6", "idle rc led", rc_led_en, 0);
    chk("R6", "idle rx_en", rx_en, 1);
  endtask

  task automatic t_program_fast;
    sd_in = 1'b1; step(20);
    tx_ir_in = 1'b1; step(15);
    chk("R10", "ir led blanked while sd high", ir_led_en, 0);
    chk("R5", "mode held while sd high", mode_o, 0);
    step(15);
    sd_in = 1'b0; step(5);
    tx_ir_in = 1'b0; step(8);
    chk("R3", "tx_ir high at fall -> 01", mode_o, 1);
  endtask

  task automatic t_program_low;
    program_level(1'b0);
    chk("R3", "tx_ir low at fall -> 00", mode_o, 0);
  endtask

  task automatic t_program_rc;
    program_burst(20);
    chk("R4", "armed burst -> 10", mode_o, 2);
    chk("R11", "mode in legal range", int'(mode_o != 2'b11), 1);
  endtask

  task automatic t_short_burst;
    program_burst(4);
    chk("R4", "short burst does not arm", mode_o, 0);
  endtask

  task automatic t_rc_drive;
    tx_ir_in = 1; step(5);
    chk("R8", "rc mode: tx_ir -> rc led", rc_led_en, 1);
    chk("R8", "rc mode: ir led off", ir_led_en, 0);
    tx_ir_in = 0; tx_rc_in = 1; step(5);
    chk("R8", "rc mode: tx_rc ignored (rc led)", rc_led_en, 0);
    chk("R8", "rc mode: tx_rc ignored (ir led)", ir_led_en, 0);
    tx_rc_in = 0; step(3);
  endtask

  task automatic t_mid_pulse;
    program_level(1'b1);
    chk("R3", "set 01 before mid pulse", mode_o, 1);
    sd_in = 1'b1; step(800);
    sd_in = 1'b0; step(8);
    chk("R5", "mid-length pulse keeps mode", mode_o, 1);
    chk("R5", "mid-length pulse no shutdown", rx_en, 1);
  endtask

  task automatic t_shutdown;
    program_burst(20);
    chk("R4", "rc mode before shutdown", mode_o, 2);
    sd_in = 1'b1; tx_ir_in = 1'b1; step(1400);
    chk("R2", "rx_en before shutdown limit", rx_en, 1);
    step(200);
    chk("R2", "rx_en in shutdown", rx_en, 0);
    chk("R2", "mode reset in shutdown", mode_o, 0);
    chk("R2", "ir led dark in shutdown", ir_led_en, 0);
    chk("R2", "rc led dark in shutdown", rc_led_en, 0);
    tx_ir_in = 1'b0; step(5);
    sd_in = 1'b0; step(8);
    chk("R2", "rx_en after shutdown", rx_en, 1);
    chk("R2", "mode after shutdown", mode_o, 0);
  endtask

  task automatic t_stuck;
    tx_ir_in = 1; step(2400);
    chk("R9", "ir led on before hold limit", ir_led_en, 1);
    step(200);
    chk("R9", "ir led off after hold limit", ir_led_en, 0);
    tx_ir_in = 0; step(5);
    tx_ir_in = 1; step(5);
    chk("R9", "ir led relights after release", ir_led_en, 1);
    tx_ir_in = 0; step(5);
    tx_rc_in = 1; step(2400);
    chk("R9", "rc led on before hold limit", rc_led_en, 1);
    step(200);
    chk("R9", "rc led off after hold limit", rc_led_en, 0);
    tx_rc_in = 0; step(5);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    t_reset();
    t_direct_drive();
    t_program_fast();
    t_program_low();
    t_program_rc();
    t_rc_drive();
    t_short_burst();
    t_mid_pulse();
    t_shutdown();
    t_stuck();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule